// File: doc/BRIEF.md
# Fused Multiply-Add Special-Case Resolver

This block is the front-end decision stage of a double-precision fused multiply-add unit. The unit computes z + x·y, or z − x·y when the negate-product input is set. For each request the block sorts the three binary64 operands into six classes: zero, subnormal, normal, infinity, quiet NaN and signalling NaN. It then decides whether the answer is already fixed by those classes. If it is, the block returns the final special value and an invalid-operation flag. If it is not, it raises a strobe that hands the operands to the general multiply, align, add and round datapath, which lies outside this block.

All of the decision logic is combinational. The outcome is registered once, so every request is answered exactly one clock later. Each request produces either a special result or a datapath hand-off, never both and never neither. The block uses the rounding mode only to choose the sign of an exact zero that comes from cancelling zeros.

Top module: `fmasc_resolver`

## Requirements
- R1: An operand is classed as follows. Exponent field zero with a nonzero fraction is subnormal. Exponent all ones with a zero fraction is infinity. Exponent all ones with a nonzero fraction is a NaN: quiet when fraction bit 51 is set, signalling when it is clear. A subnormal operand that no other rule claims goes to the datapath.
- R2: If any operand is a signalling NaN, the first one in the order z, x, y is returned with fraction bit 51 forced to 1, and invalid_flag is 1.
- R3: If there is no signalling NaN but some operand is a quiet NaN, the first one in the order z, x, y is returned unchanged, and invalid_flag is 0.
- R4: If there is no NaN and one of x and y is infinite while the other is zero, the result is the default NaN 64'h7FF8_0000_0000_0000, and invalid_flag is 1.
- R5: The effective product sign p is x[63] XOR y[63] XOR neg_prod. If the product is infinite and z is an infinity whose sign differs from p, the result is the default NaN, and invalid_flag is 1.
- R6: Any other infinite product returns an infinity with sign p: exponent all ones and fraction zero.
- R7: If the product is finite and nonzero and z is infinite, z is returned.
- R8: If the product is zero and z is nonzero (this includes infinite z), z is returned.
- R9: If the product is zero and z is zero, z is returned when z[63] equals p. Otherwise the result is a zero whose sign is 1 only when rnd_mode is 2'b11 (round toward minus infinity). The other rnd_mode codes are 00 nearest, 01 toward zero and 10 toward plus infinity.
- R10: In every remaining case go_datapath is raised, special_result is 0 and invalid_flag is 0. invalid_flag is never 1 without special_valid.
- R11: A request seen with req_valid at a rising edge is answered at that edge by exactly one of special_valid and go_datapath, each held for one cycle. A cycle without a request raises neither.
- R12: While rst_n is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Operands are valid this cycle |
| op_z | input | 64 | Addend |
| op_x | input | 64 | First multiplicand |
| op_y | input | 64 | Second multiplicand |
| neg_prod | input | 1 | Negate the product (z − x·y) |
| rnd_mode | input | 2 | Rounding mode; 2'b11 is toward minus infinity |
| special_valid | output | 1 | special_result holds the final value |
| special_result | output | 64 | Resolved special value |
| invalid_flag | output | 1 | Invalid-operation exception |
| go_datapath | output | 1 | Operands need the general datapath |

## Verification
Every result, flag and strobe appears at the first rising edge after the request is presented, and it stays for that one cycle only. The bench drives each request on a falling edge and reads the outputs on the next falling edge, half a period after the edge that registered them. It also inserts empty cycles regularly to check that no strobe appears without a request. The expected values come from a bit-field model written inside the bench, applied to every combination of twelve representative operands, both product signs and all four rounding modes.

// File: rtl/fmasc_pkg.sv
package fmasc_pkg;
  typedef enum logic [2:0] {
    CL_ZERO = 3'd0,
    CL_SUB  = 3'd1,
    CL_NORM = 3'd2,
    CL_INF  = 3'd3,
    CL_QNAN = 3'd4,
    CL_SNAN = 3'd5
  } fp_class_e;

  localparam int NUM_OPS = 3;
  localparam int RND_W   = 2;
  localparam logic [RND_W-1:0] RND_DOWN = 2'b11;
endpackage

// File: rtl/fmasc_classify.sv
module fmasc_classify
  import fmasc_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  localparam int W     = 1 + EXP_W + FRAC_W
) (
  input  logic [W-1:0] op_i,
  output fp_class_e    cls_o
);
  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;

  assign exp_f  = op_i[W-2 -: EXP_W];
  assign frac_f = op_i[FRAC_W-1:0];

  always_comb begin
    if (exp_f == '0)
      cls_o = (frac_f == '0) ? CL_ZERO : CL_SUB;
    else if (&exp_f) begin
      if (frac_f == '0)              cls_o = CL_INF;
      else if (frac_f[FRAC_W-1])     cls_o = CL_QNAN;
      else                           cls_o = CL_SNAN;
    end else
      cls_o = CL_NORM;
  end
endmodule

// File: rtl/fmasc_nan_pick.sv
module fmasc_nan_pick
  import fmasc_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  localparam int W     = 1 + EXP_W + FRAC_W
) (
  input  logic [W-1:0] ops_i [NUM_OPS],
  input  fp_class_e    cls_i [NUM_OPS],
  output logic         nan_hit_o,
  output logic         nan_inv_o,
  output logic [W-1:0] nan_val_o
);
  localparam logic [W-1:0] QUIET_BIT = {{(1+EXP_W){1'b0}}, 1'b1, {(FRAC_W-1){1'b0}}};

  logic         snan_seen, qnan_seen;
  logic [W-1:0] snan_val, qnan_val;

  // Scan from the last operand to the first so the lowest index wins.
  always_comb begin
    snan_seen = 1'b0;
    qnan_seen = 1'b0;
    snan_val  = '0;
    qnan_val  = '0;
    for (int i = NUM_OPS - 1; i >= 0; i--) begin
      if (cls_i[i] == CL_SNAN) begin
        snan_seen = 1'b1;
        snan_val  = ops_i[i] | QUIET_BIT;
      end
      if (cls_i[i] == CL_QNAN) begin
        qnan_seen = 1'b1;
        qnan_val  = ops_i[i];
      end
    end
  end

  assign nan_hit_o = snan_seen | qnan_seen;
  assign nan_inv_o = snan_seen;
  assign nan_val_o = snan_seen ? snan_val : qnan_val;
endmodule

// File: rtl/fmasc_rules.sv
module fmasc_rules
  import fmasc_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  localparam int W     = 1 + EXP_W + FRAC_W
) (
  input  fp_class_e    cls_z,
  input  fp_class_e    cls_x,
  input  fp_class_e    cls_y,
  input  logic [W-1:0] op_z,
  input  logic         sx,
  input  logic         sy,
  input  logic         neg,
  input  logic         rnd_down,
  output logic         rule_hit_o,
  output logic         rule_inv_o,
  output logic [W-1:0] rule_val_o
);
  function automatic logic [W-1:0] make_inf(input logic s);
    return {s, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
  endfunction

  function automatic logic [W-1:0] make_zero(input logic s);
    return {s, {(W-1){1'b0}}};
  endfunction

  function automatic logic [W-1:0] default_nan();
    return {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};
  endfunction

  logic psign, zsign, prod_inf, prod_zero, z_inf, z_zero;

  assign psign     = sx ^ sy ^ neg;
  assign zsign     = op_z[W-1];
  assign prod_inf  = (cls_x == CL_INF)  | (cls_y == CL_INF);
  assign prod_zero = (cls_x == CL_ZERO) | (cls_y == CL_ZERO);
  assign z_inf     = (cls_z == CL_INF);
  assign z_zero    = (cls_z == CL_ZERO);

  always_comb begin
    rule_hit_o = 1'b1;
    rule_inv_o = 1'b0;
    rule_val_o = '0;
    if (prod_inf && prod_zero) begin
      rule_inv_o = 1'b1;
      rule_val_o = default_nan();
    end else if (prod_inf) begin
      if (z_inf && (zsign != psign)) begin
        rule_inv_o = 1'b1;
        rule_val_o = default_nan();
      end else
        rule_val_o = make_inf(psign);
    end else if (prod_zero) begin
      if (z_zero && (zsign != psign))
        rule_val_o = make_zero(rnd_down);
      else
        rule_val_o = op_z;
    end else if (z_inf) begin
      rule_val_o = op_z;
    end else begin
      rule_hit_o = 1'b0;
    end
  end
endmodule

// File: rtl/fmasc_resolver.sv
module fmasc_resolver
  import fmasc_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  localparam int W     = 1 + EXP_W + FRAC_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [W-1:0]     op_z,
  input  logic [W-1:0]     op_x,
  input  logic [W-1:0]     op_y,
  input  logic             neg_prod,
  input  logic [RND_W-1:0] rnd_mode,
  output logic             special_valid,
  output logic [W-1:0]     special_result,
  output logic             invalid_flag,
  output logic             go_datapath
);
  logic [W-1:0] ops [NUM_OPS];
  fp_class_e    cls [NUM_OPS];

  assign ops[0] = op_z;
  assign ops[1] = op_x;
  assign ops[2] = op_y;

  for (genvar g = 0; g < NUM_OPS; g++) begin : g_cls
    fmasc_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
      .op_i  (ops[g]),
      .cls_o (cls[g])
    );
  end

  logic         nan_hit, nan_inv;
  logic [W-1:0] nan_val;

  fmasc_nan_pick #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_nan (
    .ops_i     (ops),
    .cls_i     (cls),
    .nan_hit_o (nan_hit),
    .nan_inv_o (nan_inv),
    .nan_val_o (nan_val)
  );

  logic         rule_hit, rule_inv;
  logic [W-1:0] rule_val;

  fmasc_rules #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_rules (
    .cls_z      (cls[0]),
    .cls_x      (cls[1]),
    .cls_y      (cls[2]),
    .op_z       (op_z),
    .sx         (op_x[W-1]),
    .sy         (op_y[W-1]),
    .neg        (neg_prod),
    .rnd_down   (rnd_mode == RND_DOWN),
    .rule_hit_o (rule_hit),
    .rule_inv_o (rule_inv),
    .rule_val_o (rule_val)
  );

  // Named decision wires; NaN handling outranks every class rule.
  logic         take_special, take_inv;
  logic [W-1:0] take_val;

  assign take_special = nan_hit | rule_hit;
  assign take_inv     = nan_hit ? nan_inv : rule_inv;
  assign take_val     = nan_hit ? nan_val : rule_val;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      special_valid  <= 1'b0;
      special_result <= '0;
      invalid_flag   <= 1'b0;
      go_datapath    <= 1'b0;
    end else begin
      special_valid  <= req_valid & take_special;
      special_result <= (req_valid & take_special) ? take_val : '0;
      invalid_flag   <= req_valid & take_special & take_inv;
      go_datapath    <= req_valid & ~take_special;
    end
  end
endmodule

// File: rtl/fmasc_resolver_chk.sv
module fmasc_resolver_chk #(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  localparam int W     = 1 + EXP_W + FRAC_W
) (
  input logic         clk,
  input logic         rst_n,
  input logic         req_valid,
  input logic [W-1:0] op_z,
  input logic [W-1:0] op_x,
  input logic [W-1:0] op_y,
  input logic         special_valid,
  input logic [W-1:0] special_result,
  input logic         invalid_flag,
  input logic         go_datapath
);
  function automatic logic is_snan(input logic [W-1:0] v);
    return (&v[W-2 -: EXP_W]) && !v[FRAC_W-1] && (v[FRAC_W-2:0] != '0);
  endfunction

  logic z_quiet_nan, any_snan;
  assign z_quiet_nan = (&op_z[W-2 -: EXP_W]) && op_z[FRAC_W-1];
  assign any_snan    = is_snan(op_z) | is_snan(op_x) | is_snan(op_y);

  p_one_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({special_valid, go_datapath}));

  p_req_answered_r11: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (special_valid ^ go_datapath));

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!special_valid && !go_datapath));

  p_flag_needs_special_r10: assert property (@(posedge clk) disable iff (!rst_n)
    invalid_flag |-> special_valid);

  p_go_clean_r10: assert property (@(posedge clk) disable iff (!rst_n)
    go_datapath |-> (special_result == '0 && !invalid_flag));

  p_invalid_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    invalid_flag |-> ((&special_result[W-2 -: EXP_W]) && special_result[FRAC_W-1]));

  p_z_qnan_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && z_quiet_nan && !any_snan) |=>
      (special_result == $past(op_z) && !invalid_flag));
endmodule

bind fmasc_resolver fmasc_resolver_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .req_valid      (req_valid),
  .op_z           (op_z),
  .op_x           (op_x),
  .op_y           (op_y),
  .special_valid  (special_valid),
  .special_result (special_result),
  .invalid_flag   (invalid_flag),
  .go_datapath    (go_datapath)
);

// File: tb/fmasc_resolver_bench.sv
module fmasc_resolver_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [63:0] op_z = '0, op_x = '0, op_y = '0;
  logic        neg_prod = 1'b0;
  logic [1:0]  rnd_mode = 2'b00;
  logic        special_valid, invalid_flag, go_datapath;
  logic [63:0] special_result;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  fmasc_resolver u_fmasc_resolver (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
    .op_z(op_z), .op_x(op_x), .op_y(op_y),
    .neg_prod(neg_prod), .rnd_mode(rnd_mode),
    .special_valid(special_valid), .special_result(special_result),
    .invalid_flag(invalid_flag), .go_datapath(go_datapath)
  );

  function automatic logic [63:0] sample_op(input int k);
    case (k)
      0:  return 64'h0000_0000_0000_0000;
      1:  return 64'h8000_0000_0000_0000;
      2:  return 64'h0000_0000_0000_0001;
      3:  return 64'h800F_FFFF_FFFF_FFFF;
      4:  return 64'h3FF0_0000_0000_0000;
      5:  return 64'hC000_0000_0000_0000;
      6:  return 64'h7FF0_0000_0000_0000;
      7:  return 64'hFFF0_0000_0000_0000;
      8:  return 64'h7FF8_0000_0000_0123;
      9:  return 64'hFFFC_0000_0000_0000;
      10: return 64'h7FF0_0000_0000_0055;
      default: return 64'hFFF4_0000_0000_0001;
    endcase
  endfunction

  function automatic bit nanq(input logic [63:0] a);
    return a[62:52] == 11'h7FF && a[51:0] != 0;
  endfunction
  function automatic bit snanq(input logic [63:0] a);
    return nanq(a) && a[51] == 1'b0;
  endfunction
  function automatic bit infq(input logic [63:0] a);
    return a[62:52] == 11'h7FF && a[51:0] == 0;
  endfunction
  function automatic bit zeroq(input logic [63:0] a);
    return a[62:0] == 0;
  endfunction
  function automatic bit subq(input logic [63:0] a);
    return a[62:52] == 0 && a[51:0] != 0;
  endfunction

  localparam logic [63:0] DNAN = 64'h7FF8_0000_0000_0000;

  task automatic model(input logic [63:0] z, x, y, input logic ng, input logic [1:0] rm,
                       output logic sv, output logic [63:0] res, output logic inv,
                       output logic go, output string tag);
    logic p;
    p = x[63] ^ y[63] ^ ng;
    sv = 1; inv = 0; go = 0; res = 0; tag = "R10";
    if (snanq(z) || snanq(x) || snanq(y)) begin
      res = snanq(z) ? z : (snanq(x) ? x : y);
      res[51] = 1'b1; inv = 1; tag = "R2";
    end else if (nanq(z) || nanq(x) || nanq(y)) begin
      res = nanq(z) ? z : (nanq(x) ? x : y); tag = "R3";
    end else if ((infq(x) && zeroq(y)) || (zeroq(x) && infq(y))) begin
      res = DNAN; inv = 1; tag = "R4";
    end else if (infq(x) || infq(y)) begin
      if (infq(z) && z[63] != p) begin res = DNAN; inv = 1; tag = "R5"; end
      else begin res = {p, 11'h7FF, 52'h0}; tag = "R6"; end
    end else if (zeroq(x) || zeroq(y)) begin
      if (zeroq(z)) begin
        res = (z[63] == p) ? z : {(rm == 2'b11), 63'h0}; tag = "R9";
      end else begin res = z; tag = "R8"; end
    end else if (infq(z)) begin
      res = z; tag = "R7";
    end else begin
      sv = 0; go = 1;
      if (subq(z) || subq(x) || subq(y)) tag = "R1";
    end
  endtask

  task automatic check_req(input logic [63:0] z, x, y, input logic ng, input logic [1:0] rm);
    logic esv, einv, ego;
    logic [63:0] eres;
    string tag;
    model(z, x, y, ng, rm, esv, eres, einv, ego, tag);
    op_z = z; op_x = x; op_y = y; neg_prod = ng; rnd_mode = rm; req_valid = 1'b1;
    @(negedge clk);
    checks++;
    if (special_valid !== esv || special_result !== eres || invalid_flag !== einv ||
        go_datapath !== ego) begin
      fails++;
      $display("FAIL %s z=%h x=%h y=%h neg=%b rm=%0d got sv=%b res=%h inv=%b go=%b exp sv=%b res=%h inv=%b go=%b",
               tag, z, x, y, ng, rm, special_valid, special_result, invalid_flag, go_datapath,
               esv, eres, einv, ego);
    end
  endtask

  task automatic check_idle();
    req_valid = 1'b0;
    op_z = 64'h7FF0_0000_0000_0001;
    @(negedge clk);
    checks++;
    if (special_valid !== 1'b0 || go_datapath !== 1'b0 || invalid_flag !== 1'b0) begin
      fails++;
      $display("FAIL R11 idle cycle got sv=%b go=%b inv=%b exp 0 0 0",
               special_valid, go_datapath, invalid_flag);
    end
  endtask

  initial begin
    int n;
    n = 0;
    req_valid = 1'b1;
    op_x = 64'h7FF0_0000_0000_0000;
    repeat (3) @(negedge clk);
    checks++;
    if (special_valid !== 1'b0 || special_result !== 64'h0 || invalid_flag !== 1'b0 ||
        go_datapath !== 1'b0) begin
      fails++;
      $display("FAIL R12 reset got sv=%b res=%h inv=%b go=%b exp 0 0 0 0",
               special_valid, special_result, invalid_flag, go_datapath);
    end
    req_valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    for (int a = 0; a < 12; a++)
      for (int b = 0; b < 12; b++)
        for (int c = 0; c < 12; c++)
          for (int ng = 0; ng < 2; ng++)
            for (int rm = 0; rm < 4; rm++) begin
              check_req(sample_op(a), sample_op(b), sample_op(c), ng[0], rm[1:0]);
              n++;
              if (n % 5 == 0) check_idle();
            end
    check_idle();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL R11 watchdog expired got running exp finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule